// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave-side command decoder for a serial NOR flash device. It runs on a fast system clock, `clk`. It watches a serial clock, an active-low frame select and a data input, all sampled on `clk`. It shifts in an opcode and then any address and dummy bytes, most significant bit first. Each command is classified by its opcode. A read-type command streams bytes taken from a backend onto the data output. A write-type command hands its received data bytes to the backend one at a time.

When the frame select returns high, the block decides whether the command may run. If it may, the block raises a one-cycle execute strobe with the opcode held on `be_cmd`. The backend owns the memory array, the status bits and the program and erase timing. It reports a long operation in progress through `be_busy`. The block ignores the array commands while that input is high.

The inputs `sck`, `cs_n` and `mosi` must already be synchronous to `clk`. Each level of `sck` must last at least two `clk` cycles. `be_rdata` must follow `be_addr` and `be_cmd` within one cycle.

Top module: `sflash_cmd_front`

## Requirements
- R1: Opcode, address and data bits are taken MSB first. A bit is captured on a rising `sck` while `cs_n` is low. The first rise in a frame carries opcode bit 7.
- R2: Opcodes 03h (read), 0Bh (fast read), 02h (page program) and D8h (sector erase) are followed by a 24-bit address, high byte first, which appears on `be_addr`. 0Bh then takes one dummy byte. ABh (signature read) takes three dummy bytes and no address.
- R3: Output data for read-type commands (03h, 0Bh, 05h, 9Fh, ABh) starts at the first falling `sck` after the header ends. The header is the opcode plus any address and dummy bytes. Each output byte is `be_rdata` loaded at its first falling edge, pulsing `be_rreq`, and then shifted out MSB first, one bit per falling edge. `be_addr` advances by one per byte and starts at 0 for commands without an address. `miso_oe` is high only during this output phase and is low in the cycle after `cs_n` is seen high.
- R4: Write-type commands execute only if `cs_n` rises after a whole number of bytes. 06h, 04h, C7h and B9h need exactly 1 byte, 01h exactly 2, D8h exactly 4, and 02h at least 5.
- R5: A read-type command executes when `cs_n` rises after any bit, once its opcode byte is complete.
- R6: For 02h, every byte after the address is driven on `be_wdata` with a one-cycle `be_wvalid`. `be_addr[7:0]` advances after each byte and wraps from FFh to 00h, leaving `be_addr[23:8]` unchanged. For 01h, only the byte after the opcode is presented.
- R7: While `be_busy` is high when the opcode completes, 03h, 0Bh, 02h, D8h and C7h are dropped: no output, no data strobe, no execute. The other opcodes still work.
- R8: An undefined opcode makes the rest of the frame ignored. No output is enabled, no data strobe is given and no execute occurs.
- R9: `be_exec` is high for exactly one cycle, in the cycle after the first `clk` edge that samples `cs_n` high. `be_cmd` then holds the frame's opcode.
- R10: `cs_n` high clears the bit, byte and command state, so a frame cut short does not affect the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for miso |
| be_addr | output | 24 | Address to backend |
| be_wdata | output | 8 | Received data byte |
| be_wvalid | output | 1 | One-cycle strobe for be_wdata |
| be_rdata | input | 8 | Byte to send, following be_addr/be_cmd |
| be_rreq | output | 1 | One-cycle strobe when be_rdata is taken |
| be_cmd | output | 8 | Opcode of the current or last frame |
| be_exec | output | 1 | One-cycle execute strobe |
| be_busy | input | 1 | Backend cycle in progress |

## Verification
A wrong bit or byte count shows in one of two ways. It can shift the first output bit, so the very first byte read comes back corrupted within eight serial clocks. Or it can shift the alignment decision, so `be_exec` appears or goes missing one cycle after the frame closes. A bad address state shows on the first output byte of a read, or on the address that goes with the first `be_wvalid`. Wrap errors show on the first program byte past a page boundary. A stuck rejected-frame or output-phase flag shows as `miso_oe` or strobes in the following frame, so every scenario is run back to back with frames of other commands.

// File: rtl/sflash_cmd_front.sv
`timescale 1ns/1ps
module sflash_cmd_front #(
  parameter int CNT_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  output logic        miso_oe,
  output logic [23:0] be_addr,
  output logic [7:0]  be_wdata,
  output logic        be_wvalid,
  input  logic [7:0]  be_rdata,
  output logic        be_rreq,
  output logic [7:0]  be_cmd,
  output logic        be_exec,
  input  logic        be_busy
);
  localparam logic [7:0] OP_WEN = 8'h06, OP_WDIS = 8'h04, OP_RSTAT = 8'h05, OP_WSTAT = 8'h01,
                         OP_RD = 8'h03, OP_RDF = 8'h0B, OP_PROG = 8'h02, OP_SERA = 8'hD8,
                         OP_CERA = 8'hC7, OP_SLEEP = 8'hB9, OP_IDENT = 8'h9F, OP_WAKE = 8'hAB;

  function automatic logic known(input logic [7:0] op);
    case (op)
      OP_WEN, OP_WDIS, OP_RSTAT, OP_WSTAT, OP_RD, OP_RDF,
      OP_PROG, OP_SERA, OP_CERA, OP_SLEEP, OP_IDENT, OP_WAKE: known = 1'b1;
      default: known = 1'b0;
    endcase
  endfunction

  function automatic logic rdtype(input logic [7:0] op);
    rdtype = (op == OP_RD) || (op == OP_RDF) || (op == OP_RSTAT) || (op == OP_IDENT) || (op == OP_WAKE);
  endfunction

  function automatic logic arrcmd(input logic [7:0] op);
    arrcmd = (op == OP_RD) || (op == OP_RDF) || (op == OP_PROG) || (op == OP_SERA) || (op == OP_CERA);
  endfunction

  function automatic logic has_addr(input logic [7:0] op);
    has_addr = (op == OP_RD) || (op == OP_RDF) || (op == OP_PROG) || (op == OP_SERA);
  endfunction

  function automatic logic [3:0] hdr_len(input logic [7:0] op);
    case (op)
      OP_RD, OP_PROG, OP_SERA, OP_WAKE: hdr_len = 4'd4;
      OP_RDF:                           hdr_len = 4'd5;
      default:                          hdr_len = 4'd1;
    endcase
  endfunction

  function automatic logic wr_ok(input logic [7:0] op, input logic [CNT_W-1:0] n);
    case (op)
      OP_PROG:  wr_ok = n >= CNT_W'(5);
      OP_SERA:  wr_ok = n == CNT_W'(4);
      OP_WSTAT: wr_ok = n == CNT_W'(2);
      default:  wr_ok = n == CNT_W'(1);
    endcase
  endfunction

  logic             sck_q, cs_q, dead, outph, miso_r;
  logic [2:0]       bitcnt;
  logic [CNT_W-1:0] bytecnt;
  logic [6:0]       sr, osr;

  wire       sck_rise  = sck & ~sck_q & ~cs_n;
  wire       sck_fall  = ~sck & sck_q & ~cs_n;
  wire       cs_rise   = cs_n & ~cs_q;
  wire [7:0] inbyte    = {sr, mosi};
  wire       byte_done = sck_rise && !dead && (bitcnt == 3'd7);
  wire       reject0   = !known(inbyte) || (arrcmd(inbyte) && be_busy);

  assign miso    = miso_r;
  assign miso_oe = outph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; dead <= 1'b0; outph <= 1'b0; miso_r <= 1'b0;
      bitcnt <= '0; bytecnt <= '0; sr <= '0; osr <= '0;
      be_addr <= '0; be_wdata <= '0; be_wvalid <= 1'b0; be_rreq <= 1'b0;
      be_cmd <= '0; be_exec <= 1'b0;
    end else begin
      sck_q     <= sck;
      cs_q      <= cs_n;
      be_wvalid <= 1'b0;
      be_rreq   <= 1'b0;
      be_exec   <= 1'b0;
      if (be_wvalid) be_addr[7:0] <= be_addr[7:0] + 8'd1;
      if (cs_n) begin
        bitcnt <= '0; bytecnt <= '0; dead <= 1'b0; outph <= 1'b0; miso_r <= 1'b0;
        if (cs_rise && !dead && bytecnt != '0)
          be_exec <= rdtype(be_cmd) || (bitcnt == 3'd0 && wr_ok(be_cmd, bytecnt));
      end else begin
        if (sck_rise && !dead) begin
          sr     <= inbyte[6:0];
          bitcnt <= bitcnt + 3'd1;
        end
        if (byte_done) begin
          if (bytecnt != '1) bytecnt <= bytecnt + CNT_W'(1);
          if (bytecnt == '0) begin
            be_cmd  <= inbyte;
            be_addr <= '0;
            dead    <= reject0;
            if (!reject0 && rdtype(inbyte) && hdr_len(inbyte) == 4'd1) outph <= 1'b1;
          end else begin
            if (has_addr(be_cmd) && bytecnt <= CNT_W'(3)) be_addr <= {be_addr[15:0], inbyte};
            if (rdtype(be_cmd) && bytecnt == CNT_W'(hdr_len(be_cmd) - 4'd1)) outph <= 1'b1;
            if ((be_cmd == OP_PROG && bytecnt >= CNT_W'(4)) || (be_cmd == OP_WSTAT && bytecnt == CNT_W'(1))) begin
              be_wdata  <= inbyte;
              be_wvalid <= 1'b1;
            end
          end
        end
        if (sck_fall && outph) begin
          if (bitcnt == 3'd0) begin
            miso_r  <= be_rdata[7];
            osr     <= be_rdata[6:0];
            be_rreq <= 1'b1;
            be_addr <= be_addr + 24'd1;
          end else begin
            miso_r <= osr[6];
            osr    <= {osr[5:0], 1'b0};
          end
        end
      end
    end
  end

  AST_OE_OFF_CS: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> !miso_oe); // R3
  AST_EXEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) be_exec |=> !be_exec); // R9
  AST_EXEC_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n) be_exec |-> $past(cs_n)); // R9
  AST_WRITE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (be_exec && !rdtype(be_cmd)) |-> ($past(bitcnt) == 3'd0)); // R4
  AST_WVALID_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    be_wvalid |-> (be_cmd == OP_PROG || be_cmd == OP_WSTAT)); // R6
  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (be_wvalid && be_cmd == OP_PROG) |=> (be_addr[23:8] == $past(be_addr[23:8]))); // R6
  AST_DEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dead |-> (!miso_oe && !be_wvalid && !be_rreq)); // R8
endmodule

// File: tb/tb_sflash_cmd_front.sv
`timescale 1ns/1ps
module tb_sflash_cmd_front;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, be_busy = 1'b0;
  logic miso, miso_oe, be_wvalid, be_rreq, be_exec;
  logic [23:0] be_addr;
  logic [7:0] be_wdata, be_rdata, be_cmd;

  sflash_cmd_front dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .be_addr(be_addr), .be_wdata(be_wdata),
    .be_wvalid(be_wvalid), .be_rdata(be_rdata), .be_rreq(be_rreq),
    .be_cmd(be_cmd), .be_exec(be_exec), .be_busy(be_busy)
  );

  always #(CLK_P/2) clk = ~clk;

  always_comb begin
    case (be_cmd)
      8'h05:   be_rdata = 8'hC3;
      8'hAB:   be_rdata = 8'h13;
      8'h9F:   be_rdata = 8'h20 + be_addr[7:0];
      default: be_rdata = be_addr[7:0] ^ 8'h5A;
    endcase
  end

  int checks = 0, errors = 0, n_exec = 0;
  logic [7:0] last_cmd;
  logic [31:0] wq[$];
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  bit oe_any = 0, cs_prev = 1, done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference comparison: enable must be low after a high select
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_prev) chk(!miso_oe, "R3 oe while deselected", 32'(miso_oe), 0);
      if (miso_oe) oe_any = 1;
      if (be_exec) begin n_exec++; last_cmd = be_cmd; end
      if (be_wvalid) wq.push_back({be_addr, be_wdata});
    end
    cs_prev = cs_n;
  end

  task automatic xbit(input logic b, output logic r);
    @(negedge clk) mosi = b;
    repeat (3) @(negedge clk);
    r = miso;
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic frame(input int nrx, input int extra);
    logic r;
    logic [7:0] by;
    n_exec = 0; wq.delete(); rxq.delete(); oe_any = 0;
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    foreach (txq[k])
      for (int i = 7; i >= 0; i--) xbit(txq[k][i], r);
    for (int j = 0; j < nrx; j++) begin
      for (int i = 7; i >= 0; i--) begin xbit(1'b0, r); by[i] = r; end
      rxq.push_back(by);
    end
    for (int i = 0; i < extra; i++) xbit(1'b0, r);
    @(negedge clk) cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(!miso_oe && !be_exec && !be_wvalid, "R9 reset outputs", {29'd0, miso_oe, be_exec, be_wvalid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    txq = '{8'h06}; frame(0, 0);
    chk(n_exec == 1, "R4 aligned enable executes", n_exec, 1);
    chk(last_cmd == 8'h06, "R9 cmd held at exec", last_cmd, 8'h06);

    txq = '{8'h06}; frame(0, 3);
    chk(n_exec == 0, "R4 misaligned enable rejected", n_exec, 0);

    txq = '{8'h03, 8'h00, 8'h12, 8'hFE}; frame(3, 3);
    chk(rxq.size() == 3 && rxq[0] == (8'hFE ^ 8'h5A), "R3 read byte0", rxq[0], 8'hFE ^ 8'h5A);
    chk(rxq[1] == (8'hFF ^ 8'h5A), "R3 read byte1", rxq[1], 8'hFF ^ 8'h5A);
    chk(rxq[2] == (8'h00 ^ 8'h5A), "R3 read byte2 addr advance", rxq[2], 8'h5A);
    chk(n_exec == 1, "R5 read ends mid-byte executes", n_exec, 1);
    chk(oe_any, "R3 output enabled", 32'(oe_any), 1);

    txq = '{8'h0B, 8'h00, 8'h00, 8'h10, 8'hFF}; frame(2, 0);
    chk(rxq[0] == (8'h10 ^ 8'h5A) && rxq[1] == (8'h11 ^ 8'h5A), "R2 fast read dummy byte",
        {rxq[0], rxq[1]}, {8'h10 ^ 8'h5A, 8'h11 ^ 8'h5A});

    txq = '{8'h05}; frame(2, 0);
    chk(rxq[0] == 8'hC3 && rxq[1] == 8'hC3, "R3 status stream", {rxq[0], rxq[1]}, 16'hC3C3);

    txq = '{8'h9F}; frame(3, 0);
    chk(rxq[0] == 8'h20 && rxq[1] == 8'h21 && rxq[2] == 8'h22, "R3 ident index from zero",
        {rxq[0], rxq[1], rxq[2]}, 24'h202122);

    txq = '{8'hAB, 8'h00, 8'h00, 8'h00}; frame(1, 0);
    chk(rxq[0] == 8'h13, "R2 signature after three dummies", rxq[0], 8'h13);

    txq = '{8'h02, 8'h00, 8'h40, 8'hFE, 8'h11, 8'h22, 8'h33}; frame(0, 0);
    chk(wq.size() == 3, "R6 program byte count", wq.size(), 3);
    if (wq.size() == 3) begin
      chk(wq[0] == 32'h0040FE11, "R6 program byte0", wq[0], 32'h0040FE11);
      chk(wq[1] == 32'h0040FF22, "R6 program byte1", wq[1], 32'h0040FF22);
      chk(wq[2] == 32'h00400033, "R6 page wrap", wq[2], 32'h00400033);
    end
    chk(n_exec == 1 && last_cmd == 8'h02, "R4 program executes", n_exec, 1);

    txq = '{8'h02, 8'h00, 8'h40, 8'h00}; frame(0, 0);
    chk(n_exec == 0, "R4 program without data rejected", n_exec, 0);

    txq = '{8'hD8, 8'h12, 8'h34, 8'h56}; frame(0, 0);
    chk(n_exec == 1, "R4 sector erase executes", n_exec, 1);
    chk(be_addr == 24'h123456, "R1 R2 address msb first", be_addr, 24'h123456);

    txq = '{8'hC7, 8'h00}; frame(0, 0);
    chk(n_exec == 0, "R4 bulk erase extra byte rejected", n_exec, 0);
    txq = '{8'hC7}; frame(0, 0);
    chk(n_exec == 1, "R4 bulk erase executes", n_exec, 1);

    txq = '{8'h01, 8'h9C}; frame(0, 0);
    chk(wq.size() == 1 && wq[0][7:0] == 8'h9C, "R6 status write byte", wq.size(), 1);
    chk(n_exec == 1, "R4 status write executes", n_exec, 1);

    txq = '{8'h77, 8'h06, 8'h00}; frame(1, 0);
    chk(n_exec == 0 && !oe_any && wq.size() == 0, "R8 undefined opcode ignored",
        {n_exec[15:0], 15'd0, oe_any}, 0);

    be_busy = 1'b1;
    txq = '{8'h03, 8'h00, 8'h00, 8'h00}; frame(1, 0);
    chk(n_exec == 0 && !oe_any, "R7 read dropped while busy", n_exec, 0);
    txq = '{8'hD8, 8'h00, 8'h00, 8'h00}; frame(0, 0);
    chk(n_exec == 0, "R7 erase dropped while busy", n_exec, 0);
    txq = '{8'h06}; frame(0, 0);
    chk(n_exec == 1, "R7 enable allowed while busy", n_exec, 1);
    be_busy = 1'b0;

    txq = '{}; frame(0, 5);
    chk(n_exec == 0, "R10 partial opcode no exec", n_exec, 0);
    txq = '{8'hD8, 8'h00, 8'h00, 8'h01}; frame(0, 0);
    chk(n_exec == 1 && be_addr == 24'h000001, "R10 clean frame after abort", be_addr, 24'h000001);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule